// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a two-way set-associative data cache for a processor load/store port. Every request is a single aligned word, either a load or a store. A request that hits completes in the cycle it is presented. The read word comes back on the same cycle, and a store updates only the matching way. A request that misses holds the processor until the block has been brought in from the next memory level. The original request is then looked up again and completes as a hit.

Allocation is done on both loads and stores, and stores are kept in the cache until their block is evicted. Each set keeps one bit that names its least recently used way, and that way is the one replaced. When the victim block is dirty, it is copied into a single-entry writeback buffer while the fill is in flight. The buffer is written out over the same next-level port once the fill has arrived. The processor may keep hitting while the buffer drains. Address width, word width, block length and set count are parameters.

Top module: `wbc_cache`

## Requirements
- R1: A byte address splits, from the least significant bit upward, into a byte-in-word field, a word-in-block field, a set index of log2(sets) bits and a tag of the remaining bits. Word k of a block travels on bits [k*WORD_W +: WORD_W] of the next-level data buses. Every next-level address is block aligned.
- R2: A request hits when either way of the indexed set is valid and holds the request tag. At most one way matches. A load hit drives the addressed word on the read-data output with the ready output high in the same cycle, with no stall.
- R3: A store hit writes only the addressed word of the matching way and marks that block dirty. The other words of the block and the other way are left unchanged.
- R4: Each set has one replacement bit naming its least recently used way, and it is cleared to way 0 by reset. After every completed access it names the way that was not used. A miss replaces the way that the bit names.
- R5: On a miss the ready output stays low. The block-aligned miss address is sent as one read request. The response block is installed with its tag as valid and clean, and the request then completes.
- R6: Evicting an invalid or clean block produces no write request.
- R7: Evicting a dirty block produces exactly one write request. It carries the victim's block-aligned address and all of its words. It is issued only after the fill read has been requested and its response accepted.
- R8: A store miss first fills the block from the next level and then performs the store. The stored word reads back, and the other words of the block come from memory.
- R9: While the writeback buffer holds a block, a new miss issues no read request. Hits still complete without stalling.
- R10: Reset clears every valid and dirty bit. After reset every access misses and no dirty data is ever written back.
- R11: Once a next-level request is presented with ready low, the valid, write flag and address stay unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request present; held until cpu_ready |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wdata | input | WORD_W | Store data |
| cpu_rdata | output | WORD_W | Load data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_we | output | 1 | 1 for a block write, 0 for a block read |
| mem_req_addr | output | ADDR_W | Block-aligned next-level address |
| mem_req_wdata | output | WORD_W*BLK_WORDS | Block being written back |
| mem_resp_valid | input | 1 | Fill data present, one cycle, only after an accepted read |
| mem_resp_rdata | input | WORD_W*BLK_WORDS | Fill block |

## Verification
The properties assume a well-behaved environment. The processor holds each request stable until ready and uses word-aligned addresses. The next level returns exactly one single-cycle response per accepted read, never before that read is accepted, and never answers writes. The bench stays within these limits by driving the processor through one task that waits for ready before releasing the request. Its memory model answers only accepted reads, after a fixed latency. It also withholds ready on a repeating pattern, and for one stretch it refuses writes altogether, so that the hold rule and the full-buffer case are both exercised.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   localparam int WAYS = 2;

   typedef enum logic [1:0] {
      MS_IDLE      = 2'd0,
      MS_FILL_REQ  = 2'd1,
      MS_FILL_WAIT = 2'd2
   } miss_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
   import wbc_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int IDX_W    = 4,
   parameter int TAG_W    = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            rd_idx,
   input  logic [TAG_W-1:0]            cmp_tag,
   output logic [WAYS-1:0]             hit_way,
   output logic [WAYS-1:0]             way_valid,
   output logic [WAYS-1:0]             way_dirty,
   output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic                        fill_en,
   input  logic                        fill_way,
   input  logic [IDX_W-1:0]            fill_idx,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic                        mark_en,
   input  logic                        mark_way,
   input  logic [IDX_W-1:0]            mark_idx
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]    tag_q [NUM_SETS];
      logic [NUM_SETS-1:0] vld_q;
      logic [NUM_SETS-1:0] drt_q;
      logic                fill_here;
      logic                mark_here;

      assign fill_here = fill_en && (fill_way == w[0]);
      assign mark_here = mark_en && (mark_way == w[0]);

      always_ff @(posedge clk) begin
         if (fill_here) begin
            tag_q[fill_idx] <= fill_tag;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= '0;
            drt_q <= '0;
         end else if (fill_here) begin
            vld_q[fill_idx] <= 1'b1;
            drt_q[fill_idx] <= 1'b0;
         end else if (mark_here) begin
            drt_q[mark_idx] <= 1'b1;
         end
      end

      assign way_valid[w] = vld_q[rd_idx];
      assign way_dirty[w] = drt_q[rd_idx];
      assign way_tag[w]   = tag_q[rd_idx];
      assign hit_way[w]   = vld_q[rd_idx] && (tag_q[rd_idx] == cmp_tag);
   end
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
   import wbc_pkg::*;
#(
   parameter int NUM_SETS  = 16,
   parameter int IDX_W     = 4,
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int WSEL_W    = 2,
   parameter int BLK_W     = 128
) (
   input  logic                       clk,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [WAYS-1:0][BLK_W-1:0] way_blk,
   input  logic                       fill_en,
   input  logic                       fill_way,
   input  logic [IDX_W-1:0]           fill_idx,
   input  logic [BLK_W-1:0]           fill_blk,
   input  logic                       st_en,
   input  logic                       st_way,
   input  logic [IDX_W-1:0]           st_idx,
   input  logic [WSEL_W-1:0]          st_wsel,
   input  logic [WORD_W-1:0]          st_wdata
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [BLK_W-1:0] blk_q [NUM_SETS];

      always_ff @(posedge clk) begin
         if (fill_en && (fill_way == w[0])) begin
            blk_q[fill_idx] <= fill_blk;
         end else if (st_en && (st_way == w[0])) begin
            blk_q[st_idx][st_wsel*WORD_W +: WORD_W] <= st_wdata;
         end
      end

      assign way_blk[w] = blk_q[rd_idx];
   end
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
   parameter int NUM_SETS = 16,
   parameter int IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                touch_en,
   input  logic [IDX_W-1:0]    touch_idx,
   input  logic                touch_way,
   output logic [NUM_SETS-1:0] lru_bits
);
   logic [NUM_SETS-1:0] lru_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lru_q <= '0;
      end else if (touch_en) begin
         lru_q[touch_idx] <= ~touch_way;
      end
   end

   assign lru_bits = lru_q;
endmodule

// File: rtl/wbc_miss_ctl.sv
module wbc_miss_ctl
   import wbc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 24,
   parameter int OFF_W  = 4,
   parameter int BLK_W  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              hit,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic              lru_way,
   input  logic              vic_dirty,
   input  logic [TAG_W-1:0]  vic_tag,
   input  logic [BLK_W-1:0]  vic_blk,
   output logic              idle,
   output logic [IDX_W-1:0]  miss_idx,
   output logic              miss_way,
   output logic              fill_en,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [BLK_W-1:0]  fill_blk,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [BLK_W-1:0]  mem_req_wdata,
   input  logic              mem_resp_valid,
   input  logic [BLK_W-1:0]  mem_resp_rdata
);
   miss_state_e       state_q;
   logic [TAG_W-1:0]  tag_q;
   logic [IDX_W-1:0]  idx_q;
   logic              way_q;
   logic              wbb_full_q;
   logic [ADDR_W-1:0] wbb_addr_q;
   logic [BLK_W-1:0]  wbb_data_q;

   logic start_miss;
   logic fill_req;
   logic drain;

   assign idle       = (state_q == MS_IDLE);
   assign start_miss = idle && cpu_req && !hit && !wbb_full_q;
   assign fill_req   = (state_q == MS_FILL_REQ);
   assign drain      = idle && wbb_full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= MS_IDLE;
         tag_q      <= '0;
         idx_q      <= '0;
         way_q      <= 1'b0;
         wbb_full_q <= 1'b0;
         wbb_addr_q <= '0;
         wbb_data_q <= '0;
      end else begin
         case (state_q)
            MS_IDLE: begin
               if (drain && mem_req_ready) begin
                  wbb_full_q <= 1'b0;
               end
               if (start_miss) begin
                  tag_q   <= cpu_tag;
                  idx_q   <= cpu_idx;
                  way_q   <= lru_way;
                  state_q <= MS_FILL_REQ;
               end
            end
            MS_FILL_REQ: begin
               if (mem_req_ready) begin
                  if (vic_dirty) begin
                     wbb_full_q <= 1'b1;
                     wbb_addr_q <= {vic_tag, idx_q, {OFF_W{1'b0}}};
                     wbb_data_q <= vic_blk;
                  end
                  state_q <= MS_FILL_WAIT;
               end
            end
            MS_FILL_WAIT: begin
               if (mem_resp_valid) begin
                  state_q <= MS_IDLE;
               end
            end
            default: state_q <= MS_IDLE;
         endcase
      end
   end

   assign miss_idx      = idx_q;
   assign miss_way      = way_q;
   assign fill_en       = (state_q == MS_FILL_WAIT) && mem_resp_valid;
   assign fill_tag      = tag_q;
   assign fill_blk      = mem_resp_rdata;

   assign mem_req_valid = fill_req || drain;
   assign mem_req_we    = !fill_req;
   assign mem_req_addr  = fill_req ? {tag_q, idx_q, {OFF_W{1'b0}}} : wbb_addr_q;
   assign mem_req_wdata = wbb_data_q;
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
   import wbc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int NUM_SETS  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cpu_req,
   input  logic                        cpu_we,
   input  logic [ADDR_W-1:0]           cpu_addr,
   input  logic [WORD_W-1:0]           cpu_wdata,
   output logic [WORD_W-1:0]           cpu_rdata,
   output logic                        cpu_ready,
   output logic                        mem_req_valid,
   input  logic                        mem_req_ready,
   output logic                        mem_req_we,
   output logic [ADDR_W-1:0]           mem_req_addr,
   output logic [WORD_W*BLK_WORDS-1:0] mem_req_wdata,
   input  logic                        mem_resp_valid,
   input  logic [WORD_W*BLK_WORDS-1:0] mem_resp_rdata
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int BYTE_W     = $clog2(WORD_BYTES);
   localparam int WSEL_W     = $clog2(BLK_WORDS);
   localparam int OFF_W      = BYTE_W + WSEL_W;
   localparam int IDX_W      = $clog2(NUM_SETS);
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
   localparam int BLK_W      = WORD_W * BLK_WORDS;

   if ((WORD_W % 8) != 0 || WORD_BYTES < 2 || (1 << BYTE_W) != WORD_BYTES) begin : g_bad_word
      $error("wbc_cache: WORD_W must be a power-of-two number of bytes, at least two");
   end
   if (BLK_WORDS < 2 || (1 << WSEL_W) != BLK_WORDS) begin : g_bad_blk
      $error("wbc_cache: BLK_WORDS must be a power of two, at least two");
   end
   if (NUM_SETS < 2 || (1 << IDX_W) != NUM_SETS) begin : g_bad_sets
      $error("wbc_cache: NUM_SETS must be a power of two, at least two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("wbc_cache: ADDR_W leaves no tag bits");
   end

   // address fields
   logic [WSEL_W-1:0] cpu_wsel;
   logic [IDX_W-1:0]  cpu_idx;
   logic [TAG_W-1:0]  cpu_tag;
   logic [BYTE_W-1:0] unused_byte_off;

   assign unused_byte_off = cpu_addr[BYTE_W-1:0];
   assign cpu_wsel        = cpu_addr[BYTE_W +: WSEL_W];
   assign cpu_idx         = cpu_addr[OFF_W +: IDX_W];
   assign cpu_tag         = cpu_addr[ADDR_W-1 -: TAG_W];

   // interconnect
   logic                       idle;
   logic [IDX_W-1:0]           miss_idx;
   logic                       miss_way;
   logic [IDX_W-1:0]           rd_idx;
   logic [WAYS-1:0]            hit_way;
   logic [WAYS-1:0]            way_valid;
   logic [WAYS-1:0]            way_dirty;
   logic [WAYS-1:0][TAG_W-1:0] way_tag;
   logic [WAYS-1:0][BLK_W-1:0] way_blk;
   logic [NUM_SETS-1:0]        lru_bits;
   logic                       lru_way;
   logic                       hit;
   logic                       hit_sel;
   logic [BLK_W-1:0]           hit_blk;
   logic                       store_en;
   logic                       fill_en;
   logic [TAG_W-1:0]           fill_tag;
   logic [BLK_W-1:0]           fill_blk;
   logic                       vic_dirty;
   logic [TAG_W-1:0]           vic_tag;
   logic [BLK_W-1:0]           vic_blk;
   logic                       touch_en;
   logic [IDX_W-1:0]           touch_idx;
   logic                       touch_way;

   assign rd_idx    = idle ? cpu_idx : miss_idx;
   assign hit       = |hit_way;
   assign hit_sel   = hit_way[1];
   assign hit_blk   = way_blk[hit_sel];
   assign cpu_rdata = hit_blk[cpu_wsel*WORD_W +: WORD_W];
   assign cpu_ready = cpu_req && idle && hit;
   assign store_en  = cpu_ready && cpu_we;
   assign lru_way   = lru_bits[rd_idx];

   assign vic_dirty = way_valid[miss_way] && way_dirty[miss_way];
   assign vic_tag   = way_tag[miss_way];
   assign vic_blk   = way_blk[miss_way];

   assign touch_en  = cpu_ready || fill_en;
   assign touch_idx = fill_en ? miss_idx : cpu_idx;
   assign touch_way = fill_en ? miss_way : hit_sel;

   wbc_tag_store #(
      .NUM_SETS (NUM_SETS),
      .IDX_W    (IDX_W),
      .TAG_W    (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (rd_idx),
      .cmp_tag   (cpu_tag),
      .hit_way   (hit_way),
      .way_valid (way_valid),
      .way_dirty (way_dirty),
      .way_tag   (way_tag),
      .fill_en   (fill_en),
      .fill_way  (miss_way),
      .fill_idx  (miss_idx),
      .fill_tag  (fill_tag),
      .mark_en   (store_en),
      .mark_way  (hit_sel),
      .mark_idx  (cpu_idx)
   );

   wbc_data_store #(
      .NUM_SETS  (NUM_SETS),
      .IDX_W     (IDX_W),
      .WORD_W    (WORD_W),
      .BLK_WORDS (BLK_WORDS),
      .WSEL_W    (WSEL_W),
      .BLK_W     (BLK_W)
   ) u_data (
      .clk      (clk),
      .rd_idx   (rd_idx),
      .way_blk  (way_blk),
      .fill_en  (fill_en),
      .fill_way (miss_way),
      .fill_idx (miss_idx),
      .fill_blk (fill_blk),
      .st_en    (store_en),
      .st_way   (hit_sel),
      .st_idx   (cpu_idx),
      .st_wsel  (cpu_wsel),
      .st_wdata (cpu_wdata)
   );

   wbc_lru #(
      .NUM_SETS (NUM_SETS),
      .IDX_W    (IDX_W)
   ) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .touch_way (touch_way),
      .lru_bits  (lru_bits)
   );

   wbc_miss_ctl #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .OFF_W  (OFF_W),
      .BLK_W  (BLK_W)
   ) u_ctl (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_req        (cpu_req),
      .hit            (hit),
      .cpu_tag        (cpu_tag),
      .cpu_idx        (cpu_idx),
      .lru_way        (lru_way),
      .vic_dirty      (vic_dirty),
      .vic_tag        (vic_tag),
      .vic_blk        (vic_blk),
      .idle           (idle),
      .miss_idx       (miss_idx),
      .miss_way       (miss_way),
      .fill_en        (fill_en),
      .fill_tag       (fill_tag),
      .fill_blk       (fill_blk),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_we     (mem_req_we),
      .mem_req_addr   (mem_req_addr),
      .mem_req_wdata  (mem_req_wdata),
      .mem_resp_valid (mem_resp_valid),
      .mem_resp_rdata (mem_resp_rdata)
   );
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 4,
   parameter int IDX_W    = 4,
   parameter int NUM_SETS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_ready,
   input logic [IDX_W-1:0]    cpu_idx,
   input logic [1:0]          hit_way,
   input logic [NUM_SETS-1:0] lru_bits,
   input logic                mem_req_valid,
   input logic                mem_req_ready,
   input logic                mem_req_we,
   input logic [ADDR_W-1:0]   mem_req_addr,
   input logic                mem_resp_valid
);
   // a block read has been accepted and its response not yet seen
   logic fill_out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_out_q <= 1'b0;
      end else if (mem_req_valid && mem_req_ready && !mem_req_we) begin
         fill_out_q <= 1'b1;
      end else if (mem_resp_valid) begin
         fill_out_q <= 1'b0;
      end
   end

   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));  // R1

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_way));  // R2

   AST_READY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> (hit_way != 2'b00));  // R2

   AST_LRU_OTHER_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> (lru_bits[$past(cpu_idx)] == ~$past(hit_way[1])));  // R4

   AST_STALL_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_out_q |-> !cpu_ready);  // R5

   AST_NO_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fill_out_q |-> !(mem_req_valid && mem_req_we));  // R7

   AST_ONE_FILL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      fill_out_q |-> !(mem_req_valid && !mem_req_we));  // R9

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)));  // R11
endmodule

bind wbc_cache wbc_cache_chk #(
   .ADDR_W   (ADDR_W),
   .OFF_W    (OFF_W),
   .IDX_W    (IDX_W),
   .NUM_SETS (NUM_SETS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_ready      (cpu_ready),
   .cpu_idx        (cpu_idx),
   .hit_way        (hit_way),
   .lru_bits       (lru_bits),
   .mem_req_valid  (mem_req_valid),
   .mem_req_ready  (mem_req_ready),
   .mem_req_we     (mem_req_we),
   .mem_req_addr   (mem_req_addr),
   .mem_resp_valid (mem_resp_valid)
);

// File: tb/wbc_cache_tb.sv
`timescale 1ns/1ps
module wbc_cache_tb;
   localparam int AW  = 32;
   localparam int WW  = 32;
   localparam int BWD = 4;
   localparam int BW  = WW * BWD;
   localparam int LAT = 3;
   localparam int MEM_WORDS = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [WW-1:0] cpu_wdata = '0;
   logic [WW-1:0] cpu_rdata;
   logic          cpu_ready;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic          mem_req_we;
   logic [AW-1:0] mem_req_addr;
   logic [BW-1:0] mem_req_wdata;
   logic          mem_resp_valid = 1'b0;
   logic [BW-1:0] mem_resp_rdata = '0;

   always #2 clk = ~clk;

   wbc_cache #(.ADDR_W(AW), .WORD_W(WW), .BLK_WORDS(BWD), .NUM_SETS(16)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
   );

   int tests = 0;
   int fails = 0;

   // next-level memory model, acts at the falling edge
   logic [WW-1:0] mem [MEM_WORDS];
   int            rd_cnt = 0, wr_cnt = 0, order_err = 0, hold_err = 0;
   logic          block_writes = 1'b0;
   logic          hs_pend = 1'b0, cap_we = 1'b0, rd_out = 1'b0, prev_wait = 1'b0, prev_we = 1'b0;
   logic [AW-1:0] cap_addr = '0, prev_addr = '0;
   logic [BW-1:0] cap_data = '0;
   int            resp_cd = 0, tick = 0;
   logic [7:0]    resp_blk = '0;

   initial begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h1000_0000 + 32'(i * 4);
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         hs_pend = 1'b0; rd_out = 1'b0; prev_wait = 1'b0;
         mem_req_ready = 1'b0; mem_resp_valid = 1'b0;
      end else begin
         if (hs_pend) begin
            hs_pend = 1'b0;
            if (cap_we) begin
               for (int k = 0; k < BWD; k++) mem[{cap_addr[11:4], 2'(k)}] = cap_data[k*WW +: WW];
               wr_cnt++;
               if (rd_out) order_err++;
            end else begin
               rd_cnt++;
               rd_out = 1'b1; resp_cd = LAT; resp_blk = cap_addr[11:4];
            end
         end
         mem_resp_valid = 1'b0;
         if (rd_out) begin
            if (resp_cd == 0) begin
               for (int k = 0; k < BWD; k++) mem_resp_rdata[k*WW +: WW] = mem[{resp_blk, 2'(k)}];
               mem_resp_valid = 1'b1;
               rd_out = 1'b0;
            end else begin
               resp_cd--;
            end
         end
         if (prev_wait && (!mem_req_valid || mem_req_addr != prev_addr || mem_req_we != prev_we))
            hold_err++;
         tick++;
         mem_req_ready = mem_req_valid && (tick % 3 != 0) && !(mem_req_we && block_writes);
         prev_wait = mem_req_valid && !mem_req_ready;
         prev_addr = mem_req_addr; prev_we = mem_req_we;
         if (mem_req_valid && mem_req_ready) begin
            hs_pend = 1'b1; cap_we = mem_req_we; cap_addr = mem_req_addr; cap_data = mem_req_wdata;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int stalls);
      stalls = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
      while (!cpu_ready) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      rd = cpu_rdata;
      @(posedge clk);
      #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
      #1;
   endtask

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic [1:0]  nrd;
      logic [1:0]  nwr;
   } vec_t;

   // set index = addr[7:4], tag = addr[31:8], word = addr[3:2]
   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h010, 32'h0,         32'h1000_0010, 2'd1, 2'd0},  // R10 R5 R6 cold miss
      '{1'b0, 32'h014, 32'h0,         32'h1000_0014, 2'd0, 2'd0},  // R2 R1 hit other word
      '{1'b1, 32'h018, 32'hDEAD_0001, 32'h0,         2'd0, 2'd0},  // R3 store hit
      '{1'b0, 32'h01C, 32'h0,         32'h1000_001C, 2'd0, 2'd0},  // R3 neighbour word untouched
      '{1'b0, 32'h110, 32'h0,         32'h1000_0110, 2'd1, 2'd0},  // R4 R6 second way
      '{1'b0, 32'h018, 32'h0,         32'hDEAD_0001, 2'd0, 2'd0},  // R3 stored word reads back
      '{1'b0, 32'h210, 32'h0,         32'h1000_0210, 2'd1, 2'd0},  // R4 R6 replaces clean way1
      '{1'b0, 32'h11C, 32'h0,         32'h1000_011C, 2'd1, 2'd1},  // R7 dirty way0 evicted
      '{1'b0, 32'h018, 32'h0,         32'hDEAD_0001, 2'd1, 2'd0},  // R7 written-back data refilled
      '{1'b1, 32'h314, 32'hBEEF_0002, 32'h0,         2'd1, 2'd0},  // R8 store miss allocates
      '{1'b0, 32'h314, 32'h0,         32'hBEEF_0002, 2'd0, 2'd0},  // R8 stored word
      '{1'b0, 32'h310, 32'h0,         32'h1000_0310, 2'd0, 2'd0},  // R8 rest from memory
      '{1'b0, 32'h024, 32'h0,         32'h1000_0024, 2'd1, 2'd0}   // R1 other set
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] rdv;
      int          st;
      int          rb, wb;

      repeat (4) @(posedge clk);
      #1;
      chk("R10 reset no request", 32'(mem_req_valid), 32'd0);
      chk("R10 reset not ready", 32'(cpu_ready), 32'd0);
      rst_n = 1'b1;
      settle();
      chk("R10 idle after reset", 32'(mem_req_valid), 32'd0);

      for (int i = 0; i < NV; i++) begin
         rb = rd_cnt; wb = wr_cnt;
         do_acc(VEC[i].we, VEC[i].addr, VEC[i].wdata, rdv, st);
         settle();
         if (!VEC[i].we) chk($sformatf("R%0d vec%0d data", (VEC[i].nwr != 0) ? 7 : 2, i), rdv, VEC[i].exp);
         chk($sformatf("R5 vec%0d reads", i), 32'(rd_cnt - rb), 32'(VEC[i].nrd));
         chk($sformatf("R6 vec%0d writes", i), 32'(wr_cnt - wb), 32'(VEC[i].nwr));
         if (VEC[i].nrd == 0) chk($sformatf("R2 vec%0d no stall", i), 32'(st), 32'd0);
         else chk($sformatf("R5 vec%0d stalled", i), 32'(st > 0), 32'd1);
      end
      chk("R7 wb word", mem[10'h006], 32'hDEAD_0001);
      chk("R7 wb full block", mem[10'h004], 32'h1000_0010);

      // R9: full writeback buffer with the next level refusing writes
      do_acc(1'b1, 32'h030, 32'hCAFE_0003, rdv, st);
      do_acc(1'b0, 32'h130, 32'h0, rdv, st);
      settle();
      block_writes = 1'b1;
      wb = wr_cnt;
      do_acc(1'b0, 32'h230, 32'h0, rdv, st);
      chk("R7 evict data", rdv, 32'h1000_0230);
      do_acc(1'b0, 32'h134, 32'h0, rdv, st);
      chk("R9 hit during full buffer", rdv, 32'h1000_0134);
      chk("R9 hit no stall", 32'(st), 32'd0);
      rb = rd_cnt;
      fork
         do_acc(1'b0, 32'h040, 32'h0, rdv, st);
         begin
            repeat (20) @(negedge clk);
            #1;
            chk("R9 miss held back", 32'(rd_cnt - rb), 32'd0);
            chk("R9 buffer not drained", 32'(wr_cnt - wb), 32'd0);
            block_writes = 1'b0;
         end
      join
      settle();
      chk("R9 miss data", rdv, 32'h1000_0040);
      chk("R7 single writeback", 32'(wr_cnt - wb), 32'd1);
      do_acc(1'b0, 32'h030, 32'h0, rdv, st);
      chk("R7 evicted store survives", rdv, 32'hCAFE_0003);

      // R10: reset drops dirty contents without writeback
      settle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      rb = rd_cnt; wb = wr_cnt;
      do_acc(1'b0, 32'h314, 32'h0, rdv, st);
      settle();
      chk("R10 dirty line lost", rdv, 32'h1000_0314);
      chk("R10 miss after reset", 32'(rd_cnt - rb), 32'd1);
      chk("R10 no writeback", 32'(wr_cnt - wb), 32'd0);

      chk("R7 order", 32'(order_err), 32'd0);
      chk("R11 hold", 32'(hold_err), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule